// File: doc/BRIEF.md
# UART Prioritized Interrupt Controller

This block holds the interrupt enable register of a serial communications controller with receive and transmit FIFOs. It gates four raw interrupt conditions with that register and resolves them into a single interrupt line and an identification byte. The four conditions come from the surrounding receiver, transmitter and modem-status logic: line status, receive data ready (or character timeout), transmit holding register empty, and modem status. The identification byte names the most urgent pending enabled condition, flags pending interrupts with an active-low bit, and reports the active FIFO mode in its top three bits.

Software reaches the block over a small register bus. Address 1 selects the enable register for reads and writes. Address 2 selects the identification register, which can only be read. Reading the identification register while it reports transmit-empty acknowledges that interrupt. The level conditions are sampled into registers once per clock. The interrupt line and the identification value are then formed combinationally from those registered values.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, the identification register reads 0x01 and irq_out is low.
- R2: A write to address 1 stores bus_wdata[5:0] in the enable register. Reads of address 1 return those six bits, with bits 7:6 always 0. A write to address 2 changes nothing.
- R3: Each condition counts only when its enable bit is set: bit 0 for receive data ready or timeout, bit 1 for transmit empty, bit 2 for line status, bit 3 for modem status. With bits 3:0 all clear, no condition is pending.
- R4: Among pending enabled conditions, identification bits 3:0 name the most urgent. The order from most to least urgent, with the code for each, is: line status 0110, receive data ready 0100, transmit empty 0010, modem status 0000.
- R5: In a FIFO mode, a pending timeout gives code 1100, which takes precedence over a plain data-ready indication at the same level. With FIFO mode off, the timeout input is ignored and identification bit 3 is 0.
- R6: Identification bit 0 is 0 exactly when an enabled condition is pending, in which case irq_out is 1. With nothing pending the code is 0001. Identification bit 4 is always 0.
- R7: Identification bits 7:5 are 000 when fifo_mode is 0 (off), 110 when fifo_mode is 1 (16-byte) and 111 when fifo_mode is 2 or 3 (64-byte).
- R8: A cycle with src_txe_evt high latches a pending transmit-empty interrupt. A read of address 2 that returns code 0010 clears it on that clock edge. A read that returns any other code leaves it set. If an event and a clearing read fall in the same cycle, the interrupt stays set.
- R9: Level conditions reach irq_out and the identification value one clock after they are driven. Read data follows bus_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 1 is enable, 2 is identification |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for the transmit-empty acknowledge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| src_line | input | 1 | Receiver line status condition (level) |
| src_rx_ready | input | 1 | Receive data ready condition (level) |
| src_rx_tmo | input | 1 | Receive character timeout condition (level) |
| src_txe_evt | input | 1 | Transmit holding register became empty (pulse) |
| src_modem | input | 1 | Modem status change condition (level) |
| fifo_mode | input | 2 | 0 off, 1 16-byte, 2 or 3 64-byte |
| irq_out | output | 1 | Interrupt request, active high |

## Verification
The bench goes after the transmit-empty acknowledge. It checks that a read showing another code leaves the interrupt set, and that a new event in the acknowledging cycle wins. A design that cleared on any identification read, or let the clear win, would lose transmit interrupts. The bench also tests the timeout with FIFO mode off, where a design that did not mask it would report 1100 or raise the line with nothing enabled. It reads in the same cycle that a condition is driven, which exposes a design that skipped or doubled the sampling register. The mode field is tested for all three encodings, and the masking is tested with every enable bit clear.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int REG_W  = 8;
    localparam int IER_W  = 6;
    localparam int SRC_N  = 4;
    localparam int CODE_W = 4;

    // priority index: 0 is most urgent
    localparam int P_LINE  = 0;
    localparam int P_RX    = 1;
    localparam int P_TXE   = 2;
    localparam int P_MODEM = 3;

    localparam logic [CODE_W-1:0] ID_NONE  = 4'b0001;
    localparam logic [CODE_W-1:0] ID_LINE  = 4'b0110;
    localparam logic [CODE_W-1:0] ID_RXRDY = 4'b0100;
    localparam logic [CODE_W-1:0] ID_TMO   = 4'b1100;
    localparam logic [CODE_W-1:0] ID_TXE   = 4'b0010;
    localparam logic [CODE_W-1:0] ID_MODEM = 4'b0000;

    typedef struct packed {
        logic line;
        logic rx;
        logic tmo;
        logic modem;
        logic txe;
    } src_state_t;

    function automatic logic [CODE_W-1:0] level_code(input int idx);
        case (idx)
            P_LINE:  return ID_LINE;
            P_RX:    return ID_RXRDY;
            P_TXE:   return ID_TXE;
            default: return ID_MODEM;
        endcase
    endfunction
endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg
    import uirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IER_W-1:0] wr_data,
    output logic [IER_W-1:0] ier
);
    logic [IER_W-1:0] ier_d, ier_q;

    always_comb begin
        ier_d = ier_q;
        if (wr_en) ier_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ier_q <= '0;
        else        ier_q <= ier_d;
    end

    assign ier = ier_q;

    // R2: a write lands, otherwise the value holds
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ier == $past(wr_data));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ier));
endmodule

// File: rtl/uirq_src_capture.sv
module uirq_src_capture
    import uirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_line,
    input  logic       in_rx,
    input  logic       in_tmo,
    input  logic       in_modem,
    input  logic       in_txe_evt,
    input  logic       txe_ack,
    output src_state_t st
);
    src_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.line  = in_line;
        s_d.rx    = in_rx;
        s_d.tmo   = in_tmo;
        s_d.modem = in_modem;
        if (in_txe_evt)   s_d.txe = 1'b1;
        else if (txe_ack) s_d.txe = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign st = s_q;

    // R8: event sets (and wins over acknowledge), acknowledge alone clears
    a_r8_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        in_txe_evt |=> st.txe);
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (txe_ack && !in_txe_evt) |=> !st.txe);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_txe_evt && !st.txe) |=> !st.txe);
    // R9: level conditions appear one clock later
    a_r9_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st.line == $past(in_line)) && (st.modem == $past(in_modem)));
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
    import uirq_pkg::*;
(
    input  logic [SRC_N-1:0]  act,
    input  logic              tmo_sel,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        code = ID_NONE;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (act[i]) begin
                if (i == P_RX && tmo_sel) code = ID_TMO;
                else                      code = level_code(i);
            end
        end
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uirq_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int ADDR_EN = 1,
    parameter int ADDR_ID = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              src_line,
    input  logic              src_rx_ready,
    input  logic              src_rx_tmo,
    input  logic              src_txe_evt,
    input  logic              src_modem,
    input  logic [1:0]        fifo_mode,
    output logic              irq_out
);
    localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(ADDR_EN);
    localparam logic [ADDR_W-1:0] A_ID = ADDR_W'(ADDR_ID);
    localparam int MODE_W = REG_W - CODE_W - 1;

    logic [IER_W-1:0]  ier;
    src_state_t        st;
    logic [SRC_N-1:0]  act;
    logic              fifo_on, tmo_sel, txe_ack;
    logic [CODE_W-1:0] code;
    logic [MODE_W-1:0] mode_bits;
    logic [REG_W-1:0]  ident;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[REG_W-1:IER_W];

    uirq_enable_reg u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr && bus_addr == A_EN),
        .wr_data (bus_wdata[IER_W-1:0]),
        .ier     (ier)
    );

    uirq_src_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_line    (src_line),
        .in_rx      (src_rx_ready),
        .in_tmo     (src_rx_tmo),
        .in_modem   (src_modem),
        .in_txe_evt (src_txe_evt),
        .txe_ack    (txe_ack),
        .st         (st)
    );

    always_comb begin
        fifo_on       = (fifo_mode != 2'd0);
        tmo_sel       = st.tmo && fifo_on;
        act[P_LINE]   = st.line && ier[2];
        act[P_RX]     = (st.rx || tmo_sel) && ier[0];
        act[P_TXE]    = st.txe && ier[1];
        act[P_MODEM]  = st.modem && ier[3];
    end

    uirq_prio_enc u_enc (
        .act     (act),
        .tmo_sel (tmo_sel),
        .code    (code)
    );

    always_comb begin
        case (fifo_mode)
            2'd0:    mode_bits = 3'b000;
            2'd1:    mode_bits = 3'b110;
            default: mode_bits = 3'b111;
        endcase
        ident   = {mode_bits, 1'b0, code};
        txe_ack = bus_rd && (bus_addr == A_ID) && (code == ID_TXE);
        irq_out = |act;
        if (bus_addr == A_EN)      bus_rdata = {{(REG_W-IER_W){1'b0}}, ier};
        else if (bus_addr == A_ID) bus_rdata = ident;
        else                       bus_rdata = '0;
    end

    // R6: the line and the active-low flag agree, bit 4 stays clear
    a_r6_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == !ident[0]);
    a_r6_bit4_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ident[4] == 1'b0);
    // R4: an enabled line-status condition is always reported first
    a_r4_line_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st.line && ier[2]) |-> ident[3:0] == ID_LINE);
    // R5: no timeout code with FIFO mode off
    a_r5_no_tmo_off: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode == 2'd0) |-> !ident[3]);
    // R3: all enables clear means nothing pending
    a_r3_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[3:0] == 4'h0) |-> !irq_out);
    // R2: top enable bits read as zero
    a_r2_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_EN) |-> bus_rdata[7:6] == 2'b00);
endmodule

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       src_line = 0, src_rx_ready = 0, src_rx_tmo = 0, src_txe_evt = 0, src_modem = 0;
    logic [1:0] fifo_mode = '0;
    logic       irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] data;
        logic       irq;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    uart_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_line(src_line),
        .src_rx_ready(src_rx_ready), .src_rx_tmo(src_rx_tmo), .src_txe_evt(src_txe_evt),
        .src_modem(src_modem), .fifo_mode(fifo_mode), .irq_out(irq_out)
    );

    // monitor: compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (bus_rdata !== e.data || irq_out !== e.irq) begin
                    errors++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             e.tag, bus_rdata, irq_out, e.data, e.irq);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [1:0] a, input logic [7:0] d, input logic irq, input string tag);
        exp_t e;
        bus_addr = a; bus_rd = 1'b1;
        e.data = d; e.irq = irq; e.tag = tag;
        sb.push_back(e);
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic txe_pulse();
        src_txe_evt = 1'b1;
        tick();
        src_txe_evt = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        tick();
        // R1
        expect_rd(2, 8'h01, 0, "R1");
        expect_rd(1, 8'h00, 0, "R1");
        // R2: store six bits, top two read zero
        wr_reg(1, 8'hFF);
        expect_rd(1, 8'h3F, 0, "R2");
        // R3: everything masked
        wr_reg(1, 8'h00);
        src_line = 1; src_rx_ready = 1; src_modem = 1;
        tick();
        expect_rd(2, 8'h01, 0, "R3");
        // R3 / R4: modem only enabled
        wr_reg(1, 8'h08);
        expect_rd(2, 8'h00, 1, "R3");
        // R4: line wins
        wr_reg(1, 8'h0F);
        expect_rd(2, 8'h06, 1, "R4");
        src_line = 0;
        tick();
        expect_rd(2, 8'h04, 1, "R4");
        // R4: transmit empty over modem
        src_rx_ready = 0;
        txe_pulse();
        expect_rd(2, 8'h02, 1, "R4");
        // R8: that read acknowledged it
        expect_rd(2, 8'h00, 1, "R8");
        // R8: read with another code does not clear
        src_rx_ready = 1;
        txe_pulse();
        expect_rd(2, 8'h04, 1, "R8");
        src_rx_ready = 0;
        tick();
        expect_rd(2, 8'h02, 1, "R8");
        expect_rd(2, 8'h00, 1, "R8");
        // R8: event in acknowledging cycle wins
        txe_pulse();
        src_txe_evt = 1;
        expect_rd(2, 8'h02, 1, "R8");
        src_txe_evt = 0;
        expect_rd(2, 8'h02, 1, "R8");
        expect_rd(2, 8'h00, 1, "R8");
        // R7 / R5: FIFO modes and timeout
        src_modem = 0; src_rx_ready = 1; fifo_mode = 2'd1;
        tick();
        expect_rd(2, 8'hC4, 1, "R7");
        src_rx_tmo = 1;
        tick();
        expect_rd(2, 8'hCC, 1, "R5");
        fifo_mode = 2'd2;
        expect_rd(2, 8'hEC, 1, "R7");
        fifo_mode = 2'd3;
        expect_rd(2, 8'hEC, 1, "R7");
        fifo_mode = 2'd0;
        expect_rd(2, 8'h04, 1, "R5");
        src_rx_ready = 0;
        tick();
        expect_rd(2, 8'h01, 0, "R5");
        // R3: timeout masked by bit 0
        wr_reg(1, 8'h0E);
        fifo_mode = 2'd1;
        expect_rd(2, 8'hC1, 0, "R3");
        // R2: write to identification address ignored
        wr_reg(2, 8'h00);
        expect_rd(1, 8'h0E, 0, "R2");
        // R9: one clock of latency
        src_rx_tmo = 0; fifo_mode = 2'd0;
        wr_reg(1, 8'h0F);
        src_line = 1;
        expect_rd(2, 8'h01, 0, "R9");
        expect_rd(2, 8'h06, 1, "R9");
        // R6: clearing the condition clears the flag
        src_line = 0;
        tick();
        expect_rd(2, 8'h01, 0, "R6");
        tick();
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule